// File: doc/BRIEF.md
# USB Host Interrupt Status Register

This block collects the interrupt-worthy events of a USB host controller into four sticky status flags. The frame and scheduling logic feed it one-cycle strobes: a frame has started, a scheduling overrun happened in the current frame, and a device on the bus signalled resume. It also sees a level request from the list engine that wants to write back the done-head pointer. Each event sets its flag. Software reads the flags through a small register port and clears any flag by writing a one to its position.

Two of the flags also affect the hardware around them. While the writeback-done flag is set, a new done-head writeback is held off: the request stays pending and gets no acknowledge until software clears the flag. A scheduling overrun is not reported at once. It is recorded, and at the next frame start the overrun flag is set and a small read-only overrun counter advances. An interrupt line is raised when any flag is set whose per-flag enable is on, provided the master enable is on.

Top module: `usbh_irq_status`

## Requirements
- R1: Address 0 reads the status flags as bit 3 = device resume, bit 2 = frame start, bit 1 = writeback done, bit 0 = scheduling overrun. All other bits of address 0 read as zero, all bits of address 3 read as zero, and every register reads zero after reset.
- R2: A write to address 0 clears each flag whose data bit is 1 on the next clock edge. Data bits that are 0 leave their flags unchanged.
- R3: If a flag is set by hardware and cleared by a write-one in the same cycle, the flag ends up set.
- R4: `resume_i` sets bit 3 on the next edge only when `resume_by_host_i` is low. A resume marked as started by host software leaves bit 3 unchanged.
- R5: `frame_start_i` sets bit 2 on the next edge.
- R6: `wb_ack_o` is high in the same cycle exactly when `wb_req_i` is high and bit 1 is clear. Bit 1 is set on the edge that ends an acknowledged cycle. While bit 1 stays set, a held request gets no acknowledge. The acknowledge comes in the cycle after the clearing write.
- R7: A pulse on `sched_ovr_i` is recorded. At the next `frame_start_i` that comes strictly after the recorded pulse, bit 0 is set and the overrun counter increments. A frame start with nothing recorded changes neither. An overrun pulse that coincides with a frame start is reported at the frame start after that one.
- R8: The overrun counter reads at address 2 in bits [1:0] and wraps from 3 to 0. Writes to address 2 do not change it.
- R9: Address 1 holds the per-flag enables in bits [3:0] and the master enable in bit 7. These bits can be written and read back. The other bits read as zero.
- R10: `irq_o` is the master enable ANDed with the OR of (flag AND enable) over the four flags. It follows the registers with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start_i | input | 1 | Strobe: frame number updated and start-of-frame sent |
| sched_ovr_i | input | 1 | Strobe: scheduling overran in this frame |
| resume_i | input | 1 | Strobe: resume signalling seen on the bus |
| resume_by_host_i | input | 1 | Qualifies `resume_i` as started by host software |
| wb_req_i | input | 1 | Level request to write back the done-head pointer |
| wb_ack_o | output | 1 | Grant for the done-head writeback in this cycle |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a done-head request that is held while the writeback-done flag is still set. The bench keeps `wb_req_i` high across the acknowledge, sees the flag rise and the grant drop for several cycles, and then clears the flag with a write while the request is still high, so the grant must come back in the very next cycle. The deferred overrun report is just as hard to see from the ports. The stimulus table places overrun pulses before a frame start, on the same cycle as a frame start, and not at all, and the counter is then driven through its wrap.

// File: rtl/usbh_irq_pkg.sv
package usbh_irq_pkg;

    localparam int EVT_N   = 4;
    localparam int IDX_OVR = 0;
    localparam int IDX_WDH = 1;
    localparam int IDX_SOF = 2;
    localparam int IDX_RES = 3;

    localparam logic [1:0] ADDR_STS = 2'd0;
    localparam logic [1:0] ADDR_ENA = 2'd1;
    localparam logic [1:0] ADDR_OVC = 2'd2;

    typedef struct packed {
        logic             master;
        logic [EVT_N-1:0] en;
    } irq_ctl_t;

endpackage

// File: rtl/usbh_irq_stickybit.sv
module usbh_irq_stickybit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
    } bit_st_t;

    bit_st_t st_d, st_q;

    // hardware set has priority over a software write-one clear
    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.flag = 1'b0;
        if (set_i) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/usbh_irq_ovr_track.sv
module usbh_irq_ovr_track #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ovr_i,
    input  logic             frame_i,
    output logic             report_o,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic             pend;
        logic [CNT_W-1:0] cnt;
    } ovr_st_t;

    ovr_st_t st_d, st_q;

    // an overrun recorded in an earlier frame is reported at this frame start
    assign report_o = frame_i & st_q.pend;

    always_comb begin
        st_d = st_q;
        if (frame_i) st_d.pend = 1'b0;
        if (ovr_i)   st_d.pend = 1'b1;
        if (report_o) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/usbh_irq_status.sv
module usbh_irq_status
    import usbh_irq_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int OVR_CNT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start_i,
    input  logic              sched_ovr_i,
    input  logic              resume_i,
    input  logic              resume_by_host_i,
    input  logic              wb_req_i,
    output logic              wb_ack_o,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    localparam int MASTER_BIT = DATA_W - 1;

    logic [EVT_N-1:0]     set_vec;
    logic [EVT_N-1:0]     clr_vec;
    logic [EVT_N-1:0]     sts_vec;
    logic                 ovr_report;
    logic [OVR_CNT_W-1:0] ovr_cnt;
    irq_ctl_t             ctl_d, ctl_q;

    logic wr_sts, wr_ena;
    assign wr_sts = reg_wr_i && (reg_addr_i == ADDR_STS);
    assign wr_ena = reg_wr_i && (reg_addr_i == ADDR_ENA);

    // done-head writeback is held off while the previous one is unacknowledged by software
    assign wb_ack_o = wb_req_i & ~sts_vec[IDX_WDH];

    always_comb begin
        set_vec          = '0;
        set_vec[IDX_RES] = resume_i & ~resume_by_host_i;
        set_vec[IDX_SOF] = frame_start_i;
        set_vec[IDX_WDH] = wb_ack_o;
        set_vec[IDX_OVR] = ovr_report;
        clr_vec          = wr_sts ? reg_wdata_i[EVT_N-1:0] : '0;
    end

    for (genvar i = 0; i < EVT_N; i++) begin : g_flag
        usbh_irq_stickybit u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[i]),
            .clr_i  (clr_vec[i]),
            .flag_o (sts_vec[i])
        );
    end

    usbh_irq_ovr_track #(.CNT_W(OVR_CNT_W)) u_ovr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovr_i    (sched_ovr_i),
        .frame_i  (frame_start_i),
        .report_o (ovr_report),
        .cnt_o    (ovr_cnt)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (wr_ena) begin
            ctl_d.en     = reg_wdata_i[EVT_N-1:0];
            ctl_d.master = reg_wdata_i[MASTER_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            ADDR_STS: reg_rdata_o[EVT_N-1:0] = sts_vec;
            ADDR_ENA: begin
                reg_rdata_o[EVT_N-1:0]  = ctl_q.en;
                reg_rdata_o[MASTER_BIT] = ctl_q.master;
            end
            ADDR_OVC: reg_rdata_o[OVR_CNT_W-1:0] = ovr_cnt;
            default:  reg_rdata_o = '0;
        endcase
    end

    assign irq_o = ctl_q.master & (|(sts_vec & ctl_q.en));

endmodule

// File: rtl/usbh_irq_status_chk.sv
module usbh_irq_status_chk #(
    parameter int DATA_W    = 8,
    parameter int OVR_CNT_W = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 frame_start_i,
    input logic                 resume_i,
    input logic                 resume_by_host_i,
    input logic                 wb_ack_o,
    input logic                 reg_wr_i,
    input logic [1:0]           reg_addr_i,
    input logic [DATA_W-1:0]    reg_wdata_i,
    input logic                 irq_o,
    input logic [3:0]           sts_vec,
    input logic                 ovr_report,
    input logic [OVR_CNT_W-1:0] ovr_cnt,
    input logic                 ctl_master
);
    logic wr0;
    assign wr0 = reg_wr_i && (reg_addr_i == 2'd0);

    assert_sof_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_i |=> sts_vec[2]);

    assert_w1c_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0 && reg_wdata_i[2] && !frame_start_i) |=> !sts_vec[2]);

    assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0 && reg_wdata_i[3] && resume_i && !resume_by_host_i) |=> sts_vec[3]);

    assert_host_resume_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_i && resume_by_host_i && !sts_vec[3]) |=> !sts_vec[3]);

    assert_wb_done_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack_o |=> sts_vec[1]);

    assert_ovr_counts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_report |=> (sts_vec[0] && ovr_cnt == OVR_CNT_W'($past(ovr_cnt) + 1'b1)));

    assert_ovr_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ovr_report |=> ovr_cnt == $past(ovr_cnt));

    assert_irq_needs_master_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ctl_master);

endmodule

bind usbh_irq_status usbh_irq_status_chk #(
    .DATA_W    (DATA_W),
    .OVR_CNT_W (OVR_CNT_W)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .frame_start_i    (frame_start_i),
    .resume_i         (resume_i),
    .resume_by_host_i (resume_by_host_i),
    .wb_ack_o         (wb_ack_o),
    .reg_wr_i         (reg_wr_i),
    .reg_addr_i       (reg_addr_i),
    .reg_wdata_i      (reg_wdata_i),
    .irq_o            (irq_o),
    .sts_vec          (sts_vec),
    .ovr_report       (ovr_report),
    .ovr_cnt          (ovr_cnt),
    .ctl_master       (ctl_q.master)
);

// File: tb/usbh_irq_status_tb.sv
module usbh_irq_status_tb;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start_i = 1'b0, sched_ovr_i = 1'b0;
    logic          resume_i = 1'b0, resume_by_host_i = 1'b0;
    logic          wb_req_i = 1'b0, wb_ack_o;
    logic          reg_wr_i = 1'b0;
    logic [1:0]    reg_addr_i = 2'd0;
    logic [DW-1:0] reg_wdata_i = '0, reg_rdata_o;
    logic          irq_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    usbh_irq_status u_dut (
        .clk(clk), .rst_n(rst_n),
        .frame_start_i(frame_start_i), .sched_ovr_i(sched_ovr_i),
        .resume_i(resume_i), .resume_by_host_i(resume_by_host_i),
        .wb_req_i(wb_req_i), .wb_ack_o(wb_ack_o),
        .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .irq_o(irq_o)
    );

    // {resume, by_host, frame, ovr, write_addr0, wdata[7:0], expected status[3:0]}
    localparam int NV = 14;
    localparam logic [16:0] VEC [NV] = '{
        {4'b0010, 1'b0, 8'h00, 4'b0100},   // R5 frame start
        {4'b0000, 1'b1, 8'h04, 4'b0000},   // R2 clear
        {4'b1100, 1'b0, 8'h00, 4'b0000},   // R4 host resume ignored
        {4'b1000, 1'b0, 8'h00, 4'b1000},   // R4 device resume
        {4'b0000, 1'b1, 8'h00, 4'b1000},   // R2 write zero keeps
        {4'b1000, 1'b1, 8'h08, 4'b1000},   // R3 set wins
        {4'b0000, 1'b1, 8'h08, 4'b0000},   // R2 clear
        {4'b0001, 1'b0, 8'h00, 4'b0000},   // R7 overrun recorded only
        {4'b0010, 1'b0, 8'h00, 4'b0101},   // R7 reported at frame start
        {4'b0000, 1'b1, 8'h05, 4'b0000},   // R2 clear two
        {4'b0010, 1'b0, 8'h00, 4'b0100},   // R7 nothing recorded
        {4'b0011, 1'b0, 8'h00, 4'b0100},   // R7 coincident not yet reported
        {4'b0010, 1'b0, 8'h00, 4'b0101},   // R7 reported one frame later
        {4'b0000, 1'b1, 8'h0F, 4'b0000}    // R2 clear all
    };

    task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // inputs are driven 1 ns after a rising edge; strobes last one cycle
    task automatic step(input logic res, input logic host, input logic frm, input logic ovr,
                        input logic wr, input logic [1:0] a, input logic [DW-1:0] d);
        resume_i = res; resume_by_host_i = host; frame_start_i = frm; sched_ovr_i = ovr;
        reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = d;
        @(posedge clk); #1;
        resume_i = 0; resume_by_host_i = 0; frame_start_i = 0; sched_ovr_i = 0;
        reg_wr_i = 0; reg_wdata_i = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [DW-1:0] v);
        reg_addr_i = a; #1; v = reg_rdata_o;
    endtask

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL R11 watchdog expired: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state and bit layout
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v); chk("R1 reset read", v, '0);
        end
        chk("R1 reset irq", {7'd0, irq_o}, '0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][16], VEC[i][15], VEC[i][14], VEC[i][13], VEC[i][12], 2'd0, VEC[i][11:4]);
            rd(2'd0, v);
            chk($sformatf("R1-vec%0d status", i), v, {4'd0, VEC[i][3:0]});
        end

        // R8 counter value, write ignored, wrap
        rd(2'd2, v); chk("R8 count after table", v, 8'd2);
        step(0, 0, 0, 0, 1, 2'd2, 8'hFF);
        rd(2'd2, v); chk("R8 write ignored", v, 8'd2);
        step(0, 0, 0, 1, 0, 2'd0, 8'h00);
        step(0, 0, 1, 0, 0, 2'd0, 8'h00);
        rd(2'd2, v); chk("R8 count three", v, 8'd3);
        step(0, 0, 0, 1, 0, 2'd0, 8'h00);
        step(0, 0, 1, 0, 0, 2'd0, 8'h00);
        rd(2'd2, v); chk("R8 wrap to zero", v, 8'd0);
        step(0, 0, 0, 0, 1, 2'd0, 8'h0F);
        rd(2'd0, v); chk("R2 cleared before writeback test", v, 8'h00);

        // R6 held done-head request
        wb_req_i = 1'b1; #1;
        chk("R6 ack when flag clear", {7'd0, wb_ack_o}, 8'd1);
        @(posedge clk); #1;
        rd(2'd0, v); chk("R6 flag set after ack", v, 8'h02);
        chk("R6 ack blocked", {7'd0, wb_ack_o}, 8'd0);
        repeat (3) @(posedge clk);
        #1 chk("R6 still blocked", {7'd0, wb_ack_o}, 8'd0);
        step(0, 0, 0, 0, 1, 2'd0, 8'h02);
        #1 chk("R6 ack next cycle after clear", {7'd0, wb_ack_o}, 8'd1);
        @(posedge clk); #1;
        wb_req_i = 1'b0;
        rd(2'd0, v); chk("R6 flag set again", v, 8'h02);
        step(0, 0, 0, 0, 1, 2'd0, 8'h02);

        // R9 / R10 enables and interrupt
        step(0, 0, 0, 0, 1, 2'd1, 8'hFF);
        rd(2'd1, v); chk("R9 enable readback masks", v, 8'h8F);
        step(0, 0, 0, 0, 1, 2'd1, 8'h04);
        step(0, 0, 1, 0, 0, 2'd0, 8'h00);
        chk("R10 no master no irq", {7'd0, irq_o}, 8'd0);
        step(0, 0, 0, 0, 1, 2'd1, 8'h84);
        chk("R10 irq with master", {7'd0, irq_o}, 8'd1);
        rd(2'd1, v); chk("R9 enable readback", v, 8'h84);
        step(0, 0, 0, 0, 1, 2'd1, 8'h81);
        chk("R10 masked flag", {7'd0, irq_o}, 8'd0);
        step(1, 0, 0, 0, 1, 2'd1, 8'h88);
        chk("R10 resume enabled", {7'd0, irq_o}, 8'd1);
        step(0, 0, 0, 0, 1, 2'd0, 8'h0F);
        chk("R10 irq drops after clear", {7'd0, irq_o}, 8'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule